// File: doc/BRIEF.md
# Two-Wire EEPROM Target Engine

This block is the target side of a two-wire serial bus that looks to a host like a byte-addressed serial EEPROM. It takes SCL and SDA as levels that have already been synchronised and oversampled by the system clock. It answers on the bus only by asserting an open-drain pull-down enable for SDA. The block finds start and stop conditions and compares the device header against a fixed type code and two strap inputs. It then loads a 16-bit word address and runs write and read transfers against an internal byte array of 2^ADDR_W locations.

A stop that ends a transfer carrying at least one data byte starts a simulated self-timed programming cycle of WR_CYCLES clocks. Until that cycle finishes, the engine does not acknowledge anything. A host finds out when the cycle is over by sending the device header again and waiting for an acknowledge. A write-protect input freezes the array. While it is high, the protocol still runs as normal, but no byte is committed.

Top module: `tw_eeprom_target`

## Requirements
- R1: A falling SDA while SCL is high (start) restarts header reception from any state. A rising SDA while SCL is high (stop) returns the engine to idle. Bytes clocked without a preceding start are never acknowledged.
- R2: The header byte is accepted only when bits 7:3 equal 10100 and bits 2:1 equal strap_i[1:0]. Bit 0 selects read (1) or write (0). On a mismatch the engine goes idle and leaves SDA released during the ninth clock.
- R3: After every accepted header byte, both address bytes (high byte first) and every write data byte, the engine pulls SDA low for the whole ninth SCL clock.
- R4: Successive write data bytes advance only the low PAGE_W address bits, so the byte after the last location of a page lands at the first location of the same page. A write of more than 2^PAGE_W bytes overwrites the earlier bytes of that page.
- R5: A stop after at least one committed data byte starts a busy period of WR_CYCLES clocks. During this period even a matching header is not acknowledged. After it ends, the header is acknowledged again.
- R6: A read header with no address phase returns the byte at the address counter, which is the last accessed location plus one. Read addressing wraps from location 2^ADDR_W-1 to location 0.
- R7: A read continues with the next location for as long as the host acknowledges each byte. A host non-acknowledge ends the read with SDA released.
- R8: With wp_i high, data bytes are still acknowledged, but no array location changes and no busy period starts.
- R9: The address loaded by a write header is kept across a repeated start, so a read header that follows returns that location first.
- R10: SDA output changes only while SCL is low. The data bits of a read byte stay stable through each SCL high phase, and SDA is released during the host's acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA line level (wired-AND of all drivers) |
| strap_i | input | 2 | Device select straps compared with header bits 2:1 |
| wp_i | input | 1 | Write protect; high blocks all array updates |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The bench checks that a 130-byte write lands back at the start of its page. A design that carried the increment into the upper address bits would instead corrupt the next page, and the read-back of the first two locations would return the stale bytes. It polls the header immediately after a write stop and again after the busy period; a design that ignored its busy timer would acknowledge the first poll. The bench reads across the top of the array to catch a counter that wraps only within a page. It sends a write under write protect and then checks that the old byte is still there and that the engine is not busy. Throughout every read it watches SDA during the SCL high phases and the host acknowledge clock, which catches output that updates on the wrong edge.

// File: rtl/tw_eep_pkg.sv
package tw_eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } tw_state_e;

  localparam logic [4:0] DEV_TYPE = 5'b10100;

  // Header accepted when type code and straps both match
  function automatic logic dev_hdr_ok(input logic [7:0] hdr, input logic [1:0] strap);
    return (hdr[7:3] == DEV_TYPE) && (hdr[2:1] == strap);
  endfunction

  // Advance only the low pw bits, keeping the page number
  function automatic logic [15:0] page_next(input logic [15:0] a, input int unsigned pw);
    logic [15:0] m;
    m = 16'((32'd1 << pw) - 32'd1);
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

endpackage

// File: rtl/tw_bus_cond.sv
module tw_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/tw_write_timer.sv
module tw_write_timer #(
  parameter int WR_CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (start_i)      cnt <= CW'(WR_CYCLES);
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end

  assign busy_o = (cnt != '0);

endmodule

// File: rtl/tw_eep_mem.sv
module tw_eep_mem #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) arr[waddr_i] <= wdata_i;
  end

  assign rdata_o = arr[raddr_i];

endmodule

// File: rtl/tw_eeprom_target.sv
module tw_eeprom_target
  import tw_eep_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 7,
  parameter int WR_CYCLES = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  // bus events
  logic scl_rise, scl_fall, start_det, stop_det;
  // engine state
  tw_state_e         st;
  logic [3:0]        bitcnt;
  logic              in_ack;
  logic              rd_mode;
  logic              host_ack;
  logic              wr_pend;
  logic [7:0]        rx_sh, tx_sh, ahi;
  logic [ADDR_W-1:0] addr;
  logic              oe;
  // named internal events
  logic              byte_done;   // falling edge closing the 8th received bit
  logic              ack_end;     // falling edge closing the 9th clock
  logic              mem_we;
  logic              wr_start;
  logic              busy_w;
  logic [7:0]        rdata;
  logic [ADDR_W-1:0] addr_page_nxt;

  tw_bus_cond u_cond (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  tw_write_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (wr_start),
    .busy_o  (busy_w)
  );

  tw_eep_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .we_i    (mem_we),
    .waddr_i (addr),
    .wdata_i (rx_sh),
    .raddr_i (addr),
    .rdata_o (rdata)
  );

  assign byte_done     = scl_fall && (bitcnt == 4'd8) && !in_ack;
  assign ack_end       = scl_fall && in_ack;
  assign mem_we        = (st == ST_WDAT) && byte_done && !wp_i;
  assign wr_start      = stop_det && wr_pend;
  assign addr_page_nxt = ADDR_W'(page_next(16'(addr), PAGE_W));
  assign sda_oe_o      = oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      in_ack   <= 1'b0;
      rd_mode  <= 1'b0;
      host_ack <= 1'b0;
      wr_pend  <= 1'b0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      ahi      <= '0;
      addr     <= '0;
      oe       <= 1'b0;
    end else if (start_det) begin
      st     <= ST_DEV;
      bitcnt <= '0;
      in_ack <= 1'b0;
      oe     <= 1'b0;
    end else if (stop_det) begin
      st      <= ST_IDLE;
      bitcnt  <= '0;
      in_ack  <= 1'b0;
      oe      <= 1'b0;
      wr_pend <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: ;
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (scl_rise && !in_ack && bitcnt < 4'd8) begin
            rx_sh  <= {rx_sh[6:0], sda_i};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            if (st == ST_DEV) begin
              if (dev_hdr_ok(rx_sh, strap_i) && !busy_w) begin
                oe      <= 1'b1;
                in_ack  <= 1'b1;
                rd_mode <= rx_sh[0];
              end else begin
                st     <= ST_IDLE;
                bitcnt <= '0;
              end
            end else begin
              oe     <= 1'b1;
              in_ack <= 1'b1;
              if (st == ST_AHI) ahi  <= rx_sh;
              if (st == ST_ALO) addr <= ADDR_W'({ahi, rx_sh});
              if (st == ST_WDAT) begin
                addr <= addr_page_nxt;
                if (!wp_i) wr_pend <= 1'b1;
              end
            end
          end else if (ack_end) begin
            in_ack <= 1'b0;
            bitcnt <= '0;
            oe     <= 1'b0;
            unique case (st)
              ST_DEV: begin
                if (rd_mode) begin
                  st    <= ST_RDAT;
                  tx_sh <= rdata;
                  oe    <= ~rdata[7];
                end else begin
                  st <= ST_AHI;
                end
              end
              ST_AHI:  st <= ST_ALO;
              default: st <= ST_WDAT;
            endcase
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            if (in_ack)                host_ack <= ~sda_i;
            else if (bitcnt < 4'd8)    bitcnt   <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (in_ack) begin
              in_ack <= 1'b0;
              bitcnt <= '0;
              if (host_ack) begin
                tx_sh <= rdata;
                oe    <= ~rdata[7];
              end else begin
                st <= ST_IDLE;
                oe <= 1'b0;
              end
            end else if (bitcnt == 4'd8) begin
              oe     <= 1'b0;
              in_ack <= 1'b1;
              addr   <= addr + ADDR_W'(1);
            end else begin
              tx_sh <= {tx_sh[6:0], 1'b0};
              oe    <= ~tx_sh[6];
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // ---------------------------------------------------------------
  // assertions
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE)); // R1

  AST_HDR_MISMATCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEV && byte_done && rx_sh[2:1] != strap_i) |=> (st == ST_IDLE && !sda_oe_o)); // R2

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WDAT && $past(st) == ST_WDAT) |-> $stable(addr[ADDR_W-1:PAGE_W])); // R4

  AST_BUSY_NO_HDR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && st == ST_DEV) |-> !sda_oe_o); // R5

  AST_WP_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wp_i |-> !mem_we); // R8

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i); // R10

endmodule

// File: tb/tw_eeprom_target_tb_top.sv
module tw_eeprom_target_tb_top;
  localparam int AW  = 10;
  localparam int PW  = 7;
  localparam int WRC = 500;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_d = 1'b1;
  logic       sda_d = 1'b1;
  logic [1:0] strap = 2'b10;
  logic       wp    = 1'b0;
  logic       sda_oe;
  logic       sda_line;
  assign sda_line = sda_d & ~sda_oe;

  tw_eeprom_target #(.ADDR_W(AW), .PAGE_W(PW), .WR_CYCLES(WRC)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_d),
    .sda_i    (sda_line),
    .strap_i  (strap),
    .wp_i     (wp),
    .sda_oe_o (sda_oe)
  );

  int n_chk  = 0;
  int n_err  = 0;
  int hi_chg = 0;
  int rel_bad = 0;
  bit done  = 0;

  logic [7:0] mdl [1 << AW];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  string      tag_q [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops observed bytes against the expected queue
  initial begin
    forever begin
      @(posedge clk);
      if (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(g == e, t, g, e);
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int page_step(input int a);
    int m;
    m = (1 << PW) - 1;
    return (a & ~m) | ((a + 1) & m);
  endfunction

  function automatic logic [7:0] hdr(input bit rd);
    return {5'b10100, strap, rd};
  endfunction

  task automatic bus_start();
    sda_d = 1'b1; wt(3);
    scl_d = 1'b1; wt(3);
    sda_d = 1'b0; wt(3);
    scl_d = 1'b0; wt(3);
  endtask

  task automatic bus_stop();
    sda_d = 1'b0; wt(3);
    scl_d = 1'b1; wt(3);
    sda_d = 1'b1; wt(3);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_d = b[i]; wt(3);
      scl_d = 1'b1; wt(4);
      scl_d = 1'b0; wt(1);
    end
    sda_d = 1'b1; wt(3);
    scl_d = 1'b1; wt(2);
    acked = !sda_line;
    wt(2);
    scl_d = 1'b0; wt(1);
  endtask

  task automatic read_byte(input bit hack, output logic [7:0] b);
    sda_d = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      logic s1;
      wt(3);
      scl_d = 1'b1; wt(2);
      s1 = sda_line;
      b[i] = s1;
      wt(2);
      if (sda_line != s1) hi_chg++;
      scl_d = 1'b0; wt(1);
    end
    sda_d = hack ? 1'b0 : 1'b1; wt(3);
    scl_d = 1'b1; wt(2);
    if (sda_oe) rel_bad++;
    wt(2);
    scl_d = 1'b0; wt(1);
    sda_d = 1'b1;
  endtask

  task automatic send_addr(input int a, input string tag);
    bit k;
    send_byte(8'(a >> 8), k); chk(k, tag, k, 1);
    send_byte(8'(a), k);      chk(k, tag, k, 1);
  endtask

  // write n bytes base+i starting at a; model follows the page rule
  task automatic write_seq(input int a, input int n, input logic [7:0] base, input string tag);
    bit k;
    int p;
    p = a & ((1 << AW) - 1);
    bus_start();
    send_byte(hdr(1'b0), k); chk(k, tag, k, 1);
    send_addr(a, tag);
    for (int i = 0; i < n; i++) begin
      send_byte(base + 8'(i), k); chk(k, tag, k, 1);
      if (!wp) mdl[p] = base + 8'(i);
      p = page_step(p);
    end
    bus_stop();
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      read_byte(i < n - 1, b);
      got_q.push_back(b);
    end
    bus_stop();
  endtask

  task automatic expect_at(input int a, input string tag);
    exp_q.push_back(mdl[a & ((1 << AW) - 1)]);
    tag_q.push_back(tag);
  endtask

  task automatic rand_read(input int a, input int n);
    bit k;
    bus_start();
    send_byte(hdr(1'b0), k); chk(k, "R9 header", k, 1);
    send_addr(a, "R9 address");
    bus_start();
    send_byte(hdr(1'b1), k); chk(k, "R9 read header", k, 1);
    read_n(n);
  endtask

  task automatic poll(output bit k);
    bus_start();
    send_byte(hdr(1'b0), k);
    bus_stop();
  endtask

  initial begin
    bit k;
    wt(5);
    rst_n = 1'b1;
    wt(5);
    chk(sda_oe == 1'b0, "R1 reset released", sda_oe, 0);

    // header mismatches
    bus_start();
    send_byte({5'b10100, ~strap, 1'b0}, k); chk(!k, "R2 strap mismatch", k, 0);
    bus_stop();
    bus_start();
    send_byte({5'b10110, strap, 1'b0}, k); chk(!k, "R2 type mismatch", k, 0);
    bus_stop();

    // no start: ignored
    send_byte(hdr(1'b0), k); chk(!k, "R1 no start", k, 0);
    bus_stop();

    // byte write, then busy polling
    write_seq(16'h0010, 1, 8'h5A, "R3");
    poll(k); chk(!k, "R5 busy poll", k, 0);
    wt(WRC + 50);
    poll(k); chk(k, "R5 ready poll", k, 1);

    // page write wrapping at page end
    write_seq(16'h00FE, 4, 8'h40, "R3 page");
    wt(WRC + 50);
    expect_at(16'h0080, "R4 wrapped byte"); rand_read(16'h0080, 1);
    expect_at(16'h0081, "R6 current address"); bus_start();
    send_byte(hdr(1'b1), k); chk(k, "R6 header", k, 1);
    read_n(1);
    expect_at(16'h00FE, "R7 seq 0"); expect_at(16'h00FF, "R7 seq 1");
    rand_read(16'h00FE, 2);

    // read wrap across top of array, upper address bits ignored
    write_seq(16'hFFFF, 1, 8'hC3, "R3");
    wt(WRC + 50);
    write_seq(16'h0000, 1, 8'h3C, "R3");
    wt(WRC + 50);
    expect_at(16'h03FF, "R6 top"); expect_at(16'h0000, "R6 wrap to 0");
    rand_read(16'h03FF, 2);

    // write protect
    wp = 1'b1;
    write_seq(16'h0010, 1, 8'hFF, "R8 ack");
    poll(k); chk(k, "R8 not busy", k, 1);
    wp = 1'b0;
    expect_at(16'h0010, "R8 unchanged"); rand_read(16'h0010, 1);

    // page overflow overwrites earlier bytes of the page
    write_seq(16'h0200, 130, 8'h00, "R3 long");
    wt(WRC + 50);
    expect_at(16'h0200, "R4 overwrite 0"); expect_at(16'h0201, "R4 overwrite 1");
    expect_at(16'h0202, "R4 kept 2");
    rand_read(16'h0200, 3);
    chk(mdl[16'h0200] == 8'h80, "R4 model", mdl[16'h0200], 8'h80);

    wt(20);
    chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    chk(hi_chg == 0, "R10 stable while SCL high", hi_chg, 0);
    chk(rel_bad == 0, "R10 released on host ack", rel_bad, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule